// File: doc/BRIEF.md
# Configurable Buffer and Decoder Cell

This cell sits in the routing of a programmable-logic fabric, next to a local logic unit. It carries ten bit-lanes, split into a low nibble (lanes 3:0), a high nibble (lanes 7:4) and a 2-bit control pair (lanes 9:8). Static configuration gives each group one of two roles.

- **Buffer role.** The group passes data along the fabric.
- **Decoder role.** The group contributes one AND term to a wide AND-OR-invert function. The result appears on a single decoder output.

Inputs arrive from a left bus, a right bus and a central bus fed by the logic unit. A single 3-state control input is shared by the cell. Physical 3-state drivers are modelled as a data bus plus a per-lane enable bus in each direction. A lane whose enable is low drives 0 on its data bit.

The decoder output can be fed back as the enable of either nibble. This lets a few decoder lanes, optionally qualified by the 3-state input, switch a buffered nibble on and off. The cell is purely combinational and holds no state. Its data pins are plain buses with no valid/ready handshake: every output follows its inputs within the same cycle, so there is no back-pressure to manage.

Top module: `bdc_cell`

## Requirements
- R1: Bit g of `cfg_role` selects the role of group g, where 1 means decoder. Group 0 is lanes 3:0, group 1 is lanes 7:4 and group 2 is lanes 9:8. All eight combinations are legal.
- R2: A buffer group routes data by its 3-bit direction code:
  - 0: left_in to right_out.
  - 1: right_in to left_out.
  - 2: ctr_in to left_out.
  - 3: ctr_in to right_out.
  - 4: ctr_in to both outputs.
  - 5 to 7: nothing is driven.
- R3: A lane whose enable is 0 drives 0 on its data output. A group in decoder role enables none of its lanes on either side, whatever its inputs.
- R4: The enable of a driven nibble side is selected by the nibble's 3-bit enable code:
  - 0: always on.
  - 1: tri_in.
  - 2: the inverse of tri_in.
  - 5 to 7: always off.
- R5: Nibble enable codes 3 and 4 feed the decoder back into the enable:
  - 3: the enable is dec_out.
  - 4: the enable is dec_out AND tri_in.
- R6: The control pair, in buffer role, always enables every side its direction code drives, regardless of tri_in.
- R7: A decoder group's term is the AND of all its lanes taken from one source, chosen by its 2-bit source code:
  - 0: left_in.
  - 1: right_in.
  - 2 or 3: ctr_in.
- R8: The terms of the decoder-role groups combine through AND when `cfg_dec_or` is 0 and through OR when it is 1. A buffer-role group contributes 1 to AND and 0 to OR.
- R9: When `cfg_dec_inv` is 1 and at least one group is a decoder, dec_out is the inverse of the combined value.
- R10: When all three groups are buffers, dec_out equals `cfg_const`, ignoring the gate and invert settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| left_in | input | 10 | Data arriving from the left bus |
| right_in | input | 10 | Data arriving from the right bus |
| ctr_in | input | 10 | Data from the local logic unit |
| tri_in | input | 1 | Shared 3-state control |
| cfg_role | input | 3 | Role per group, 1 = decoder |
| cfg_dir_lo | input | 3 | Direction code, lanes 3:0 |
| cfg_dir_hi | input | 3 | Direction code, lanes 7:4 |
| cfg_dir_ctl | input | 3 | Direction code, lanes 9:8 |
| cfg_src_lo | input | 2 | Decoder source, lanes 3:0 |
| cfg_src_hi | input | 2 | Decoder source, lanes 7:4 |
| cfg_src_ctl | input | 2 | Decoder source, lanes 9:8 |
| cfg_oe_lo | input | 3 | Enable code, lanes 3:0 |
| cfg_oe_hi | input | 3 | Enable code, lanes 7:4 |
| cfg_dec_or | input | 1 | Combining gate: 0 AND, 1 OR |
| cfg_dec_inv | input | 1 | Invert decoder result |
| cfg_const | input | 1 | Decoder output when no group decodes |
| left_out | output | 10 | Data driven to the left |
| left_en | output | 10 | Per-lane left drive enable |
| right_out | output | 10 | Data driven to the right |
| right_en | output | 10 | Per-lane right drive enable |
| dec_out | output | 1 | Decoder / constant output |

## Verification
The sweep covers every role combination under both gate types and both polarities. It deliberately includes the unused direction and enable codes, which would show up a decoder that leaks stray drive. Buffer groups inside an AND or OR must act as identity values; a wrong identity makes dec_out stick at 0 or 1 in mixed modes. Directed cases exercise the nibble enable fed back from dec_out, gated and ungated by tri_in; a swapped or missing gate leaves the nibble driving while the decoder is false. Further directed cases check the control pair ignoring tri_in, and the all-buffer constant ignoring the invert bit.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  localparam int NIB_W   = 4;
  localparam int CTL_W   = 2;
  localparam int GROUPS  = 3;
  localparam int LANES   = 2 * NIB_W + CTL_W;

  // direction codes
  localparam logic [2:0] DIR_L2R  = 3'd0;
  localparam logic [2:0] DIR_R2L  = 3'd1;
  localparam logic [2:0] DIR_C2L  = 3'd2;
  localparam logic [2:0] DIR_C2R  = 3'd3;
  localparam logic [2:0] DIR_C2LR = 3'd4;

  // nibble enable codes
  localparam logic [2:0] OE_ON      = 3'd0;
  localparam logic [2:0] OE_TRI     = 3'd1;
  localparam logic [2:0] OE_TRI_N   = 3'd2;
  localparam logic [2:0] OE_DEC     = 3'd3;
  localparam logic [2:0] OE_DEC_TRI = 3'd4;

  // decoder source codes
  localparam logic [1:0] SRC_LEFT  = 2'd0;
  localparam logic [1:0] SRC_RIGHT = 2'd1;
endpackage

// File: rtl/bdc_oe_ctrl.sv
module bdc_oe_ctrl
  import bdc_pkg::*;
(
  input  logic [2:0] code,
  input  logic       tri_in,
  input  logic       dec_in,
  output logic       oe
);
  always_comb begin
    case (code)
      OE_ON:      oe = 1'b1;
      OE_TRI:     oe = tri_in;
      OE_TRI_N:   oe = ~tri_in;
      OE_DEC:     oe = dec_in;
      OE_DEC_TRI: oe = dec_in & tri_in;
      default:    oe = 1'b0;
    endcase
  end
endmodule

// File: rtl/bdc_lane_group.sv
module bdc_lane_group
  import bdc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] left_in,
  input  logic [W-1:0] right_in,
  input  logic [W-1:0] ctr_in,
  input  logic         role_dec,
  input  logic [2:0]   dir,
  input  logic [1:0]   src,
  input  logic         oe,
  output logic [W-1:0] left_out,
  output logic [W-1:0] left_en,
  output logic [W-1:0] right_out,
  output logic [W-1:0] right_en,
  output logic         term
);
  logic [W-1:0] term_src;
  logic [W-1:0] l_data, r_data;
  logic         l_use, r_use;

  // decoder term: AND of the selected source
  always_comb begin
    case (src)
      SRC_LEFT:  term_src = left_in;
      SRC_RIGHT: term_src = right_in;
      default:   term_src = ctr_in;
    endcase
    term = &term_src;
  end

  // buffer routing
  always_comb begin
    l_use  = 1'b0;
    r_use  = 1'b0;
    l_data = '0;
    r_data = '0;
    case (dir)
      DIR_L2R:  begin r_use = 1'b1; r_data = left_in;  end
      DIR_R2L:  begin l_use = 1'b1; l_data = right_in; end
      DIR_C2L:  begin l_use = 1'b1; l_data = ctr_in;   end
      DIR_C2R:  begin r_use = 1'b1; r_data = ctr_in;   end
      DIR_C2LR: begin
        l_use  = 1'b1; l_data = ctr_in;
        r_use  = 1'b1; r_data = ctr_in;
      end
      default: ;
    endcase
  end

  always_comb begin
    left_en   = (!role_dec && l_use && oe) ? '1 : '0;
    right_en  = (!role_dec && r_use && oe) ? '1 : '0;
    left_out  = l_data & left_en;
    right_out = r_data & right_en;
  end

  always_comb begin
    if (role_dec)
      AST_DEC_SILENT: assert ((left_en | right_en) == '0) else $error("decoder group drives"); // R3
    if (!role_dec && dir == DIR_L2R)
      AST_L2R_NO_LEFT: assert (left_en == '0) else $error("left driven in L2R"); // R2
  end
endmodule

// File: rtl/bdc_dec_combine.sv
module bdc_dec_combine #(
  parameter int NG = 3
) (
  input  logic [NG-1:0] role,
  input  logic [NG-1:0] term,
  input  logic          op_or,
  input  logic          inv,
  input  logic          const_val,
  output logic          dec
);
  logic and_acc, or_acc;

  always_comb begin
    and_acc = 1'b1;
    or_acc  = 1'b0;
    for (int g = 0; g < NG; g++) begin
      if (role[g]) begin
        and_acc = and_acc & term[g];
        or_acc  = or_acc | term[g];
      end
    end
    if (role == '0) dec = const_val;
    else            dec = (op_or ? or_acc : and_acc) ^ inv;
  end

  always_comb begin
    if (role != '0 && op_or && (role & term) == '0)
      AST_OR_IDENTITY: assert (dec == inv) else $error("OR identity broken"); // R8
    if (role != '0 && !op_or && (~role | term) == '1)
      AST_AND_IDENTITY: assert (dec == !inv) else $error("AND identity broken"); // R8
  end
endmodule

// File: rtl/bdc_cell.sv
module bdc_cell
  import bdc_pkg::*;
(
  input  logic [LANES-1:0] left_in,
  input  logic [LANES-1:0] right_in,
  input  logic [LANES-1:0] ctr_in,
  input  logic             tri_in,
  input  logic [2:0]       cfg_role,
  input  logic [2:0]       cfg_dir_lo,
  input  logic [2:0]       cfg_dir_hi,
  input  logic [2:0]       cfg_dir_ctl,
  input  logic [1:0]       cfg_src_lo,
  input  logic [1:0]       cfg_src_hi,
  input  logic [1:0]       cfg_src_ctl,
  input  logic [2:0]       cfg_oe_lo,
  input  logic [2:0]       cfg_oe_hi,
  input  logic             cfg_dec_or,
  input  logic             cfg_dec_inv,
  input  logic             cfg_const,
  output logic [LANES-1:0] left_out,
  output logic [LANES-1:0] left_en,
  output logic [LANES-1:0] right_out,
  output logic [LANES-1:0] right_en,
  output logic             dec_out
);
  localparam int CTL_LO = 2 * NIB_W;

  logic [2:0] dir_nib [2];
  logic [1:0] src_nib [2];
  logic [2:0] oe_nib  [2];
  logic [GROUPS-1:0] term;

  assign dir_nib[0] = cfg_dir_lo;
  assign dir_nib[1] = cfg_dir_hi;
  assign src_nib[0] = cfg_src_lo;
  assign src_nib[1] = cfg_src_hi;
  assign oe_nib[0]  = cfg_oe_lo;
  assign oe_nib[1]  = cfg_oe_hi;

  for (genvar g = 0; g < 2; g++) begin : g_nib
    logic nib_oe;

    bdc_oe_ctrl u_oe (
      .code   (oe_nib[g]),
      .tri_in (tri_in),
      .dec_in (dec_out),
      .oe     (nib_oe)
    );

    bdc_lane_group #(.W(NIB_W)) u_grp (
      .left_in   (left_in[g*NIB_W +: NIB_W]),
      .right_in  (right_in[g*NIB_W +: NIB_W]),
      .ctr_in    (ctr_in[g*NIB_W +: NIB_W]),
      .role_dec  (cfg_role[g]),
      .dir       (dir_nib[g]),
      .src       (src_nib[g]),
      .oe        (nib_oe),
      .left_out  (left_out[g*NIB_W +: NIB_W]),
      .left_en   (left_en[g*NIB_W +: NIB_W]),
      .right_out (right_out[g*NIB_W +: NIB_W]),
      .right_en  (right_en[g*NIB_W +: NIB_W]),
      .term      (term[g])
    );

    always_comb begin
      if (!cfg_role[g] && oe_nib[g] == OE_DEC && dir_nib[g] == DIR_L2R)
        AST_FEEDBACK_OE: assert (right_en[g*NIB_W +: NIB_W] == {NIB_W{dec_out}})
          else $error("nibble enable not following decoder"); // R5
    end
  end

  // control pair: no 3-state capability, always drives when buffering
  bdc_lane_group #(.W(CTL_W)) u_ctl (
    .left_in   (left_in[CTL_LO +: CTL_W]),
    .right_in  (right_in[CTL_LO +: CTL_W]),
    .ctr_in    (ctr_in[CTL_LO +: CTL_W]),
    .role_dec  (cfg_role[2]),
    .dir       (cfg_dir_ctl),
    .src       (cfg_src_ctl),
    .oe        (1'b1),
    .left_out  (left_out[CTL_LO +: CTL_W]),
    .left_en   (left_en[CTL_LO +: CTL_W]),
    .right_out (right_out[CTL_LO +: CTL_W]),
    .right_en  (right_en[CTL_LO +: CTL_W]),
    .term      (term[2])
  );

  bdc_dec_combine #(.NG(GROUPS)) u_comb (
    .role      (cfg_role),
    .term      (term),
    .op_or     (cfg_dec_or),
    .inv       (cfg_dec_inv),
    .const_val (cfg_const),
    .dec       (dec_out)
  );

  always_comb begin
    if (!cfg_role[2] && cfg_dir_ctl == DIR_C2LR)
      AST_CTL_DRIVES: assert ((left_en[CTL_LO +: CTL_W] & right_en[CTL_LO +: CTL_W]) == '1)
        else $error("control pair not driving"); // R6
  end
endmodule

// File: tb/bdc_cell_test.sv
module bdc_cell_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [9:0] left_in, right_in, ctr_in;
  logic       tri_in;
  logic [2:0] cfg_role, cfg_dir_lo, cfg_dir_hi, cfg_dir_ctl, cfg_oe_lo, cfg_oe_hi;
  logic [1:0] cfg_src_lo, cfg_src_hi, cfg_src_ctl;
  logic       cfg_dec_or, cfg_dec_inv, cfg_const;
  logic [9:0] left_out, left_en, right_out, right_en;
  logic       dec_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [9:0] e_lo, e_len, e_ro, e_ren;
  logic       e_dec;

  bdc_cell uut (
    .left_in(left_in), .right_in(right_in), .ctr_in(ctr_in), .tri_in(tri_in),
    .cfg_role(cfg_role), .cfg_dir_lo(cfg_dir_lo), .cfg_dir_hi(cfg_dir_hi),
    .cfg_dir_ctl(cfg_dir_ctl), .cfg_src_lo(cfg_src_lo), .cfg_src_hi(cfg_src_hi),
    .cfg_src_ctl(cfg_src_ctl), .cfg_oe_lo(cfg_oe_lo), .cfg_oe_hi(cfg_oe_hi),
    .cfg_dec_or(cfg_dec_or), .cfg_dec_inv(cfg_dec_inv), .cfg_const(cfg_const),
    .left_out(left_out), .left_en(left_en), .right_out(right_out),
    .right_en(right_en), .dec_out(dec_out)
  );

  task automatic check(input string req, input string what, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int grp(input int i);
    return (i < 4) ? 0 : (i < 8) ? 1 : 2;
  endfunction

  task automatic model();
    logic [2:0] t;
    logic acc;
    for (int g = 0; g < 3; g++) begin
      logic [1:0] s;
      int lo, w;
      s  = (g == 0) ? cfg_src_lo : (g == 1) ? cfg_src_hi : cfg_src_ctl;
      lo = g * 4;
      w  = (g == 2) ? 2 : 4;
      t[g] = 1'b1;
      for (int k = 0; k < w; k++) begin
        logic b;
        b = (s == 0) ? left_in[lo+k] : (s == 1) ? right_in[lo+k] : ctr_in[lo+k];
        t[g] = t[g] & b;
      end
    end
    if (cfg_role == 3'b000) e_dec = cfg_const;
    else begin
      acc = cfg_dec_or ? 1'b0 : 1'b1;
      for (int g = 0; g < 3; g++)
        if (cfg_role[g]) acc = cfg_dec_or ? (acc | t[g]) : (acc & t[g]);
      e_dec = acc ^ cfg_dec_inv;
    end
    for (int i = 0; i < 10; i++) begin
      int g;
      logic oe;
      logic [2:0] d, c;
      g = grp(i);
      d = (g == 0) ? cfg_dir_lo : (g == 1) ? cfg_dir_hi : cfg_dir_ctl;
      c = (g == 0) ? cfg_oe_lo : cfg_oe_hi;
      if (g == 2) oe = 1'b1;
      else case (c)
        3'd0: oe = 1'b1;
        3'd1: oe = tri_in;
        3'd2: oe = !tri_in;
        3'd3: oe = e_dec;
        3'd4: oe = e_dec && tri_in;
        default: oe = 1'b0;
      endcase
      if (cfg_role[g]) oe = 1'b0;
      e_len[i] = oe && (d == 1 || d == 2 || d == 4);
      e_ren[i] = oe && (d == 0 || d == 3 || d == 4);
      e_lo[i]  = e_len[i] && ((d == 1) ? right_in[i] : ctr_in[i]);
      e_ro[i]  = e_ren[i] && ((d == 0) ? left_in[i] : ctr_in[i]);
    end
  endtask

  task automatic clear_cfg();
    left_in = '0; right_in = '0; ctr_in = '0; tri_in = 0;
    cfg_role = 0; cfg_dir_lo = 0; cfg_dir_hi = 0; cfg_dir_ctl = 0;
    cfg_src_lo = 0; cfg_src_hi = 0; cfg_src_ctl = 0;
    cfg_oe_lo = 0; cfg_oe_hi = 0; cfg_dec_or = 0; cfg_dec_inv = 0; cfg_const = 0;
  endtask

  initial begin
    clear_cfg();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state: all buffer, L2R, always-on enables, constant 0
    check("R3", "left_en at reset", left_en, 10'h000);
    check("R6", "right_en at reset", right_en, 10'h3FF);
    check("R10", "dec_out at reset", {9'b0, dec_out}, 10'h000);

    // R1/R3: middle nibble as decoder stays silent
    @(posedge clk);
    cfg_role = 3'b010; cfg_dir_lo = 4; cfg_dir_hi = 4; cfg_dir_ctl = 4; ctr_in = 10'h3FF;
    @(negedge clk);
    check("R1", "left_en with hi nibble decoding", left_en, 10'h30F);
    check("R3", "right_out with hi nibble decoding", right_out, 10'h30F);

    // R6: control pair ignores tri_in
    @(posedge clk);
    clear_cfg(); cfg_dir_ctl = 4; ctr_in = 10'h200; tri_in = 0; cfg_oe_lo = 1; cfg_oe_hi = 1;
    @(negedge clk);
    check("R6", "ctl pair enables with tri low", left_en & 10'h300, 10'h300);
    check("R6", "ctl pair data", left_out & 10'h300, 10'h200);
    check("R4", "nibble enable follows tri", right_en & 10'h0FF, 10'h000);

    // R5: decoder feedback into low nibble
    @(posedge clk);
    clear_cfg(); cfg_role = 3'b100; cfg_src_ctl = 2; ctr_in = 10'h300;
    cfg_oe_lo = 3; cfg_dir_lo = 0; left_in = 10'h005;
    @(negedge clk);
    check("R5", "nibble enable with dec true", right_en & 10'h00F, 10'h00F);
    check("R5", "nibble data with dec true", right_out & 10'h00F, 10'h005);
    @(posedge clk); ctr_in = 10'h100;
    @(negedge clk);
    check("R5", "nibble enable with dec false", right_en & 10'h00F, 10'h000);
    @(posedge clk); ctr_in = 10'h300; cfg_oe_lo = 4; tri_in = 0;
    @(negedge clk);
    check("R5", "dec AND tri with tri low", right_en & 10'h00F, 10'h000);
    @(posedge clk); tri_in = 1;
    @(negedge clk);
    check("R5", "dec AND tri with tri high", right_en & 10'h00F, 10'h00F);

    // R7/R9: source selection and inversion
    @(posedge clk);
    clear_cfg(); cfg_role = 3'b111; cfg_src_lo = 0; cfg_src_hi = 2; cfg_src_ctl = 2;
    left_in = 10'h00F; ctr_in = 10'h3F0;
    @(negedge clk);
    check("R7", "AND of left/center sources", {9'b0, dec_out}, 10'h001);
    @(posedge clk); cfg_src_lo = 1;
    @(negedge clk);
    check("R7", "low nibble from right source", {9'b0, dec_out}, 10'h000);
    @(posedge clk); cfg_dec_inv = 1;
    @(negedge clk);
    check("R9", "inverted decoder", {9'b0, dec_out}, 10'h001);

    // R10: all buffer ignores gate and invert
    @(posedge clk);
    clear_cfg(); cfg_const = 1; cfg_dec_or = 1; cfg_dec_inv = 1;
    @(negedge clk);
    check("R10", "constant one", {9'b0, dec_out}, 10'h001);

    // sweep: all role patterns, both gates, both polarities
    for (int r = 0; r < 8; r++)
      for (int op = 0; op < 2; op++)
        for (int iv = 0; iv < 2; iv++)
          for (int k = 0; k < 30; k++) begin
            @(posedge clk);
            cfg_role = 3'(r); cfg_dec_or = op[0]; cfg_dec_inv = iv[0];
            cfg_const = 1'($urandom);
            cfg_dir_lo = 3'($urandom); cfg_dir_hi = 3'($urandom); cfg_dir_ctl = 3'($urandom);
            cfg_oe_lo = 3'($urandom); cfg_oe_hi = 3'($urandom);
            cfg_src_lo = 2'($urandom); cfg_src_hi = 2'($urandom); cfg_src_ctl = 2'($urandom);
            tri_in = 1'($urandom);
            // bias toward all-ones so AND terms are often true
            left_in  = 10'($urandom) | ((k % 3 == 0) ? 10'h3FF : 10'h000);
            right_in = 10'($urandom) | ((k % 3 == 1) ? 10'h3FF : 10'h000);
            ctr_in   = 10'($urandom) | ((k % 3 == 2) ? 10'h3FF : 10'h000);
            @(negedge clk);
            model();
            check("R8", "dec_out sweep", {9'b0, dec_out}, {9'b0, e_dec});
            check("R2", "left_out sweep", left_out, e_lo);
            check("R2", "right_out sweep", right_out, e_ro);
            check("R4", "left_en sweep", left_en, e_len);
            check("R4", "right_en sweep", right_en, e_ren);
          end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule